// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block sits at the end of a page-table walk. It turns the permission bits gathered at each walk level into one allowed read/write/execute set for the access. It then decides whether the requested load, store or fetch may proceed. When the access is refused, it builds the page-fault error code that is reported to the exception logic.

The walker presents one request per transfer on a valid/ready input. A request holds:
- the per-level user, writable and no-execute bits, with a mask of the levels that took part in the walk;
- a reserved-bit flag found during the walk;
- the protection key of the leaf entry;
- the privilege and supervisor-access-prevention context of the access;
- the control mode bits;
- two key-rights registers, one for user pages and one for supervisor pages.

The result is registered and leaves on a valid/ready output.

Back-pressure works as follows. The input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result that is not taken stays unchanged on the output until `out_ready` is seen high. The mode bits and key registers are plain control pins and are sampled on the accepting edge.

Top module: `pg_perm_eval`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An accepted request's result appears with `out_valid` high on the next clock edge. While `out_valid && !out_ready`, the output fields and `out_valid` hold their values. Reset empties the output register.
- R2: Only levels whose `in_lvl_mask` bit is 1 take part. The effective user and writable bits are the AND over those levels, and the effective no-execute bit is their OR. With an empty mask the effective bits are user=1, writable=1, no-execute=0.
- R3: When `in_rsvd` is 1 the access faults with the reserved bit (bit 3) set and P clear, whatever the other rules say.
- R4: A user access (`in_user`=1) to a page whose effective user bit is 0 is a protection fault.
- R5: Read is granted unless the access is supervisor with `in_smap`=1 to a user page. In that case write is also refused.
- R6: Write is granted when the effective writable bit is 1, or when the access is supervisor and `cfg_wp`=0, subject to R5.
- R7: Execute is granted when the effective no-execute bit is 0 and at least one of these holds: the access is user, `cfg_smep`=0, or the page is a supervisor page.
- R8: The key-rights word applied is `pkr_user` for user pages when `cfg_pke`=1, or `pkr_sup` for supervisor pages when `cfg_pks`=1; otherwise no key restriction applies. The walker supplies the leaf entry's bits [62:59] on `in_pkey` as key k. Bit 2k of the word is access-disable and bit 2k+1 is write-disable.
- R9: Access-disable removes read and write. Write-disable removes write only for a user access or when `cfg_wp`=1. A load or store refused by the key rights faults with error bits PK (bit 5) and P (bit 0). A fetch never takes a key fault.
- R10: `in_acc` encodes 0 load, 1 store, 2 fetch; 3 is treated as a load. Checks apply in this order: reserved (R3), then the user-page check (R4), then keys (R9). Otherwise a missing requested right is a protection fault with P set.
- R11: On any fault the error code adds bit 2 for a user access and bit 1 for a store. It adds bit 4 for a fetch only when `cfg_nxe` or `cfg_smep` is 1. On a fault `out_perm` is 0. With no fault `out_ecode` is 0 and `out_perm` gives the granted set after key masking, as {execute, write, read} in bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 as load |
| in_user | input | 1 | Access made at user privilege |
| in_smap | input | 1 | Supervisor access is subject to user-page access prevention |
| in_lvl_mask | input | LEVELS | Levels that took part in the walk |
| in_lvl_user | input | LEVELS | User bit per level |
| in_lvl_rw | input | LEVELS | Writable bit per level |
| in_lvl_nx | input | LEVELS | No-execute bit per level |
| in_rsvd | input | 1 | Walk found a reserved-bit violation |
| in_pkey | input | KEY_W | Leaf entry protection key (entry bits [62:59]) |
| cfg_wp | input | 1 | Write protect for supervisor accesses |
| cfg_smep | input | 1 | Supervisor execute prevention on user pages |
| cfg_nxe | input | 1 | No-execute feature enabled |
| cfg_pke | input | 1 | Keys enabled for user pages |
| cfg_pks | input | 1 | Keys enabled for supervisor pages |
| pkr_user | input | 2*2**KEY_W | Key-rights word for user pages |
| pkr_sup | input | 2*2**KEY_W | Key-rights word for supervisor pages |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_perm | output | 3 | Granted {execute, write, read} |
| out_fault | output | 1 | Access refused |
| out_ecode | output | 6 | Error code: P0 W1 U2 RSVD3 ID4 PK5 |

## Verification
Every result is due on the clock edge after the edge that accepted its request. If the consumer stalls, it stays due on each later cycle until it is taken; `in_ready` is due in the same cycle as the output state that drives it. The bench models this in a behavioural reference. At each rising edge the reference moves a computed expected result into its own output slot using the same acceptance rule. At the following falling edge it compares `in_ready`, `out_valid` and, when a result is held, all result fields against that slot. A stalled result is therefore compared again on every cycle it is held.

// File: rtl/pgp_pkg.sv
package pgp_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  localparam int EC_P    = 0;
  localparam int EC_W    = 1;
  localparam int EC_U    = 2;
  localparam int EC_RSVD = 3;
  localparam int EC_ID   = 4;
  localparam int EC_PK   = 5;
  localparam int EC_BITS = 6;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } rights_t;

endpackage

// File: rtl/pgp_combine.sv
module pgp_combine #(
  parameter int LEVELS = 4
) (
  input  logic [LEVELS-1:0] lvl_mask,
  input  logic [LEVELS-1:0] lvl_user,
  input  logic [LEVELS-1:0] lvl_rw,
  input  logic [LEVELS-1:0] lvl_nx,
  output logic              eff_user,
  output logic              eff_rw,
  output logic              eff_nx
);

  logic [LEVELS-1:0] user_term;
  logic [LEVELS-1:0] rw_term;
  logic [LEVELS-1:0] nx_term;

  // Masked-out levels contribute the identity of each reduction
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign user_term[g] = lvl_user[g] | ~lvl_mask[g];
    assign rw_term[g]   = lvl_rw[g]   | ~lvl_mask[g];
    assign nx_term[g]   = lvl_nx[g]   &  lvl_mask[g];
  end

  assign eff_user = &user_term;
  assign eff_rw   = &rw_term;
  assign eff_nx   = |nx_term;

endmodule

// File: rtl/pgp_rights.sv
module pgp_rights
  import pgp_pkg::*;
(
  input  logic    is_user,
  input  logic    smap_chk,
  input  logic    eff_user,
  input  logic    eff_rw,
  input  logic    eff_nx,
  input  logic    wp,
  input  logic    smep,
  output rights_t base,
  output logic    user_viol
);

  logic smap_block;

  assign user_viol  = is_user & ~eff_user;
  assign smap_block = ~is_user & smap_chk & eff_user;

  always_comb begin
    base.r = ~smap_block;
    base.w = ~smap_block & (eff_rw | (~is_user & ~wp));
    base.x = ~eff_nx & (is_user | ~smep | ~eff_user);
  end

endmodule

// File: rtl/pgp_keys.sv
module pgp_keys
  import pgp_pkg::*;
#(
  parameter int KEY_W = 4,
  localparam int PKR_W = 2 << KEY_W
) (
  input  logic [KEY_W-1:0] pkey,
  input  logic             eff_user,
  input  logic             is_user,
  input  logic             wp,
  input  logic             pke,
  input  logic             pks,
  input  logic [PKR_W-1:0] pkr_user,
  input  logic [PKR_W-1:0] pkr_sup,
  output rights_t          kmask
);

  logic [PKR_W-1:0] sel;
  logic             ad;
  logic             wd;

  always_comb begin
    if (eff_user) sel = pke ? pkr_user : '0;
    else          sel = pks ? pkr_sup  : '0;
  end

  assign ad = sel[{pkey, 1'b0}];
  assign wd = sel[{pkey, 1'b1}];

  always_comb begin
    kmask.x = 1'b1;
    kmask.r = ~ad;
    kmask.w = ~ad & ~(wd & (is_user | wp));
  end

endmodule

// File: rtl/pg_perm_eval.sv
module pg_perm_eval
  import pgp_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int KEY_W  = 4,
  localparam int PKR_W = 2 << KEY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_acc,
  input  logic              in_user,
  input  logic              in_smap,
  input  logic [LEVELS-1:0] in_lvl_mask,
  input  logic [LEVELS-1:0] in_lvl_user,
  input  logic [LEVELS-1:0] in_lvl_rw,
  input  logic [LEVELS-1:0] in_lvl_nx,
  input  logic              in_rsvd,
  input  logic [KEY_W-1:0]  in_pkey,
  input  logic              cfg_wp,
  input  logic              cfg_smep,
  input  logic              cfg_nxe,
  input  logic              cfg_pke,
  input  logic              cfg_pks,
  input  logic [PKR_W-1:0]  pkr_user,
  input  logic [PKR_W-1:0]  pkr_sup,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_perm,
  output logic              out_fault,
  output logic [EC_BITS-1:0] out_ecode
);

  logic    eff_user, eff_rw, eff_nx;
  logic    user_viol;
  rights_t base, kmask, granted;
  acc_e    acc;
  logic    want_ok, key_ok, pk_viol;
  logic              fault_n;
  logic [EC_BITS-1:0] ecode_n;
  logic [2:0]         perm_n;

  pgp_combine #(.LEVELS(LEVELS)) u_combine (
    .lvl_mask (in_lvl_mask),
    .lvl_user (in_lvl_user),
    .lvl_rw   (in_lvl_rw),
    .lvl_nx   (in_lvl_nx),
    .eff_user (eff_user),
    .eff_rw   (eff_rw),
    .eff_nx   (eff_nx)
  );

  pgp_rights u_rights (
    .is_user   (in_user),
    .smap_chk  (in_smap),
    .eff_user  (eff_user),
    .eff_rw    (eff_rw),
    .eff_nx    (eff_nx),
    .wp        (cfg_wp),
    .smep      (cfg_smep),
    .base      (base),
    .user_viol (user_viol)
  );

  pgp_keys #(.KEY_W(KEY_W)) u_keys (
    .pkey     (in_pkey),
    .eff_user (eff_user),
    .is_user  (in_user),
    .wp       (cfg_wp),
    .pke      (cfg_pke),
    .pks      (cfg_pks),
    .pkr_user (pkr_user),
    .pkr_sup  (pkr_sup),
    .kmask    (kmask)
  );

  assign acc     = acc_e'(in_acc);
  assign granted = base & kmask;

  always_comb begin
    unique case (acc)
      ACC_STORE: begin want_ok = granted.w; key_ok = kmask.w; end
      ACC_FETCH: begin want_ok = granted.x; key_ok = 1'b1;    end
      default:   begin want_ok = granted.r; key_ok = kmask.r; end
    endcase
  end

  assign pk_viol = ~key_ok;

  // Fault ordering: reserved, user page, key, plain protection
  always_comb begin
    fault_n = 1'b1;
    ecode_n = '0;
    if (in_rsvd)        ecode_n[EC_RSVD] = 1'b1;
    else if (user_viol) ecode_n[EC_P] = 1'b1;
    else if (pk_viol) begin
      ecode_n[EC_P]  = 1'b1;
      ecode_n[EC_PK] = 1'b1;
    end
    else if (!want_ok)  ecode_n[EC_P] = 1'b1;
    else                fault_n = 1'b0;

    if (fault_n) begin
      ecode_n[EC_U]  = in_user;
      ecode_n[EC_W]  = (acc == ACC_STORE);
      ecode_n[EC_ID] = (acc == ACC_FETCH) & (cfg_nxe | cfg_smep);
    end
    perm_n = fault_n ? 3'b000 : granted;
  end

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_perm  <= '0;
      out_fault <= 1'b0;
      out_ecode <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_perm  <= perm_n;
        out_fault <= fault_n;
        out_ecode <= ecode_n;
      end
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable({out_perm, out_fault, out_ecode})); // R1
  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R1
  AST_RSVD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ecode[EC_RSVD] |-> out_fault && !out_ecode[EC_P] && !out_ecode[EC_PK]); // R3
  AST_PK_NOT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ecode[EC_PK] |-> out_ecode[EC_P] && !out_ecode[EC_ID]); // R9
  AST_FAULT_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault |-> out_perm == 3'b000); // R11
  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_fault |-> out_ecode == '0); // R11

endmodule

// File: tb/pg_perm_eval_bench.sv
module pg_perm_eval_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_acc = 2'd0;
  logic        in_user = 1'b0, in_smap = 1'b0, in_rsvd = 1'b0;
  logic [3:0]  in_lvl_mask = 4'hF, in_lvl_user = 4'h0, in_lvl_rw = 4'hF, in_lvl_nx = 4'h0;
  logic [3:0]  in_pkey = 4'h0;
  logic        cfg_wp = 1'b0, cfg_smep = 1'b0, cfg_nxe = 1'b0, cfg_pke = 1'b0, cfg_pks = 1'b0;
  logic [31:0] pkr_user = '0, pkr_sup = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_perm;
  logic        out_fault;
  logic [5:0]  out_ecode;

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_tag  = "R1";
  bit    rand_bp  = 1'b0;

  always #2 clk = ~clk;

  pg_perm_eval u_pg_perm_eval (
    .clk, .rst_n, .in_valid, .in_ready, .in_acc, .in_user, .in_smap,
    .in_lvl_mask, .in_lvl_user, .in_lvl_rw, .in_lvl_nx, .in_rsvd, .in_pkey,
    .cfg_wp, .cfg_smep, .cfg_nxe, .cfg_pke, .cfg_pks, .pkr_user, .pkr_sup,
    .out_valid, .out_ready, .out_perm, .out_fault, .out_ecode
  );

  // Behavioural reference: returns {perm[2:0], fault, ecode[5:0]}
  function automatic logic [9:0] ref_eval();
    logic eu, ew, en, r, w, x, kr, kw, want, kwant, f;
    logic [31:0] sel;
    logic [5:0]  ec;
    logic [2:0]  perm;
    int k;
    eu = 1; ew = 1; en = 0;
    for (int i = 0; i < 4; i++)
      if (in_lvl_mask[i]) begin
        eu = eu & in_lvl_user[i];
        ew = ew & in_lvl_rw[i];
        en = en | in_lvl_nx[i];
      end
    r = !(!in_user && in_smap && eu);
    w = r && (ew || (!in_user && !cfg_wp));
    x = !en && (in_user || !cfg_smep || !eu);
    k = int'(in_pkey);
    sel = eu ? (cfg_pke ? pkr_user : 32'd0) : (cfg_pks ? pkr_sup : 32'd0);
    kr = 1; kw = 1;
    if (sel[2*k]) begin kr = 0; kw = 0; end
    else if (sel[2*k+1] && (in_user || cfg_wp)) kw = 0;
    r = r & kr;
    w = w & kw;
    if (in_acc == 2'd1)      begin want = w; kwant = kw; end
    else if (in_acc == 2'd2) begin want = x; kwant = 1;  end
    else                     begin want = r; kwant = kr; end
    f = 1; ec = 0;
    if (in_rsvd)               ec = 6'h08;
    else if (in_user && !eu)   ec = 6'h01;
    else if (!kwant)           ec = 6'h21;
    else if (!want)            ec = 6'h01;
    else                       f = 0;
    if (f) begin
      if (in_user) ec = ec | 6'h04;
      if (in_acc == 2'd1) ec = ec | 6'h02;
      if (in_acc == 2'd2 && (cfg_nxe || cfg_smep)) ec = ec | 6'h10;
      perm = 3'b000;
    end else perm = {x, w, r};
    return {perm, f, ec};
  endfunction

  logic       exp_v = 1'b0;
  logic [9:0] exp_d = '0;
  string      exp_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) exp_v <= 1'b0;
    else if (!exp_v || out_ready) begin
      exp_v <= in_valid;
      if (in_valid) begin
        exp_d   <= ref_eval();
        exp_tag <= cur_tag;
      end
    end
  end

  task automatic check(string req, int act, int exp, string what);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R1", int'(in_ready), int'(!exp_v || out_ready), "in_ready");
      check("R1", int'(out_valid), int'(exp_v), "out_valid");
      if (exp_v && out_valid) begin
        check(exp_tag, int'(out_perm),  int'(exp_d[9:7]), "perm");
        check(exp_tag, int'(out_fault), int'(exp_d[6]),   "fault");
        check(exp_tag, int'(out_ecode), int'(exp_d[5:0]), "ecode");
      end
    end
  end

  // Called at a falling edge with inputs set; returns at a falling edge after acceptance
  task automatic push(string tag);
    logic rdy;
    cur_tag  = tag;
    in_valid = 1'b1;
    forever begin
      rdy = in_ready;
      @(posedge clk);
      @(negedge clk);
      if (rand_bp) out_ready = ($urandom_range(0, 2) != 0);
      if (rdy) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic base_req(logic [1:0] acc, logic usr);
    in_acc = acc; in_user = usr; in_smap = 0; in_rsvd = 0;
    in_lvl_mask = 4'hF; in_lvl_user = usr ? 4'hF : 4'h0; in_lvl_rw = 4'hF; in_lvl_nx = 4'h0;
    in_pkey = 0; cfg_wp = 0; cfg_smep = 0; cfg_nxe = 0; cfg_pke = 0; cfg_pks = 0;
    pkr_user = 0; pkr_sup = 0;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(out_valid), 0, "reset out_valid");
    check("R1", int'(in_ready), 1, "reset in_ready");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 supervisor load, all supervisor levels: full rights
    base_req(2'd0, 0); push("R2");
    // R2 masked-out level with user=0 is ignored
    base_req(2'd0, 1); in_lvl_user = 4'b0111; in_lvl_mask = 4'b0111; push("R2");
    // R2 empty mask: user page, writable, executable
    base_req(2'd1, 1); in_lvl_mask = 4'h0; in_lvl_user = 4'h0; in_lvl_rw = 4'h0; in_lvl_nx = 4'hF; push("R2");
    // R4 user access, one level supervisor
    base_req(2'd0, 1); in_lvl_user = 4'b1101; push("R4");
    // R6 user store, one level read-only
    base_req(2'd1, 1); in_lvl_rw = 4'b1011; push("R6");
    // R6 supervisor store, read-only, wp off then on
    base_req(2'd1, 0); in_lvl_rw = 4'b1110; push("R6");
    base_req(2'd1, 0); in_lvl_rw = 4'b1110; cfg_wp = 1; push("R6");
    // R5 supervisor access prevention on a user page
    base_req(2'd0, 0); in_lvl_user = 4'hF; in_smap = 1; push("R5");
    base_req(2'd2, 0); in_lvl_user = 4'hF; in_smap = 1; push("R5");
    // R7 execute prevention for supervisor on user page
    base_req(2'd2, 0); in_lvl_user = 4'hF; cfg_smep = 1; push("R7");
    base_req(2'd2, 1); in_lvl_nx = 4'b0100; cfg_nxe = 1; push("R7");
    // R11 fetch fault without nxe/smep: no I/D bit
    base_req(2'd2, 1); in_lvl_nx = 4'b0001; push("R11");
    // R8/R9 user key access-disable
    base_req(2'd0, 1); in_pkey = 4'd5; cfg_pke = 1; pkr_user = 32'h1 << 10; push("R9");
    base_req(2'd0, 1); in_pkey = 4'd5; cfg_pke = 0; pkr_user = 32'h1 << 10; push("R8");
    base_req(2'd2, 1); in_pkey = 4'd5; cfg_pke = 1; pkr_user = 32'h1 << 10; push("R9");
    // R8 key 15 uses the top two bits of the word
    base_req(2'd1, 1); in_pkey = 4'd15; cfg_pke = 1; pkr_user = 32'h8000_0000; push("R8");
    // R9 supervisor key write-disable, wp off then on
    base_req(2'd1, 0); in_pkey = 4'd3; cfg_pks = 1; pkr_sup = 32'h1 << 7; push("R9");
    base_req(2'd1, 0); in_pkey = 4'd3; cfg_pks = 1; pkr_sup = 32'h1 << 7; cfg_wp = 1; push("R9");
    // R8 supervisor page ignores user word
    base_req(2'd1, 0); in_pkey = 4'd3; cfg_pke = 1; pkr_user = 32'hFFFF_FFFF; push("R8");
    // R3 reserved fault overrides user violation
    base_req(2'd1, 1); in_lvl_user = 4'h0; in_rsvd = 1; push("R3");
    base_req(2'd2, 0); in_rsvd = 1; cfg_nxe = 1; push("R3");
    // R10 code 3 behaves as load; priority user check before keys
    base_req(2'd3, 0); in_smap = 1; in_lvl_user = 4'hF; push("R10");
    base_req(2'd0, 1); in_lvl_user = 4'b1110; in_pkey = 1; cfg_pks = 1; pkr_sup = 32'h4; push("R10");

    // R1 back-pressure: stall output while two requests arrive
    out_ready = 1'b0;
    base_req(2'd0, 0); push("R1");
    base_req(2'd1, 1); in_lvl_rw = 4'h0; cur_tag = "R1"; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    out_ready = 1'b1;
    push("R1");
    @(negedge clk);

    // R10 random mix under random back-pressure
    rand_bp = 1'b1;
    for (int n = 0; n < 400; n++) begin
      in_acc = 2'($urandom_range(0, 3));
      in_user = 1'($urandom); in_smap = 1'($urandom); in_rsvd = ($urandom_range(0, 9) == 0);
      in_lvl_mask = 4'($urandom); in_lvl_user = 4'($urandom) | 4'($urandom);
      in_lvl_rw = 4'($urandom) | 4'($urandom); in_lvl_nx = 4'($urandom) & 4'($urandom);
      in_pkey = 4'($urandom);
      cfg_wp = 1'($urandom); cfg_smep = 1'($urandom); cfg_nxe = 1'($urandom);
      cfg_pke = 1'($urandom); cfg_pks = 1'($urandom);
      pkr_user = $urandom; pkr_sup = $urandom;
      push("R10");
    end
    rand_bp = 1'b0;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule